// File: doc/BRIEF.md
# Supply Supervisor Reset Generator

The block watches two supply rails and two push-button style reset requests, and from them builds a system reset and a power-good flag for the logic downstream. Each rail arrives as a one-bit digitized comparator result meaning "this rail is at or above 95% of its nominal value". The system reset is held active while rail 2 is below its threshold or either manual reset request is active. It is released only after all three conditions have been good for a long hold-off period. The power-good flag follows rail 1 alone.

Both outputs model open-drain pins. Each output is an output-low enable: a 1 means the pad is pulled low, and a 0 means the pad is released and floats high externally. All inputs are asynchronous. Each passes through a two-flop synchronizer before any decision is made. The rail 2 path filters out short rising pulses, so reset release never starts on a glitch. The rail 1 path filters out short falling dips, so power-good does not flicker. The filter lengths and the hold-off are clock-cycle parameters. The defaults correspond to roughly 30 µs and 120 ms at a 200 MHz clock.

The power-good pin may be wired back into a manual reset input. Rail 1 then also gates the system reset, with no change inside the block.

Top module: `supply_supervisor`

## Requirements
- R1: While `rst_n` is low, and afterwards until the conditions below are met, `rst_out_oe_o` is 1 (reset pin driven low) and `pg_out_oe_o` is 1 (power-good pin driven low).
- R2: Suppose `rail2_ok_i` rises to 1 while `mr_a_n_i` and `mr_b_n_i` are both 1, and all three then stay unchanged. Then `rst_out_oe_o` drops to 0 after exactly `RISE_DG_CYCLES + HOLD_CYCLES + 2` rising clock edges, counted from the first edge that sees the new input.
- R3: When `rail2_ok_i` falls to 0, `rst_out_oe_o` becomes 1 after the third clock edge that sees the low level.
- R4: When either `mr_a_n_i` or `mr_b_n_i` is 0, `rst_out_oe_o` becomes 1 after the second clock edge that sees the low level.
- R5: Any loss of a condition, even for one cycle, during the hold-off clears the hold-off count. Release then needs the full `HOLD_CYCLES` again, so a partial count never releases the reset. After a manual input returns high with rail 2 already qualified, release follows after `HOLD_CYCLES + 2` edges.
- R6: A high pulse on `rail2_ok_i` lasting fewer than `RISE_DG_CYCLES` clock cycles does not release the reset.
- R7: When `rail1_ok_i` rises to 1, `pg_out_oe_o` becomes 0 after the third clock edge that sees the high level.
- R8: When `rail1_ok_i` falls to 0 and stays low, `pg_out_oe_o` becomes 1 after exactly `PG_DG_CYCLES + 2` edges. A low pulse shorter than `PG_DG_CYCLES` cycles leaves `pg_out_oe_o` at 0.
- R9: When the power-good pin is wired to `mr_b_n_i` (pin level = NOT `pg_out_oe_o`), rail 1 low keeps the reset asserted, and rail 1 high lets the reset release after the normal hold-off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of the block's own state |
| rail2_ok_i | input | 1 | Rail 2 comparator result, 1 = at or above 95% |
| rail1_ok_i | input | 1 | Rail 1 comparator result, 1 = at or above 95% |
| mr_a_n_i | input | 1 | Manual reset request A, active low, default high |
| mr_b_n_i | input | 1 | Manual reset request B, active low, default high |
| rst_out_oe_o | output | 1 | Reset pin pull-low enable, 1 = reset asserted |
| pg_out_oe_o | output | 1 | Power-good pin pull-low enable, 1 = rail 1 not good |

## Verification
The bench counts edges exactly on every path. A synchronizer, filter or counter that is one stage off moves release, assertion or power-good by a cycle, and the check in the neighbouring cycle catches it. A single-cycle manual reset pulse during an almost-complete hold-off must restart the full delay. A counter that only pauses, or releases on a stale partial count, would free the reset early. Sub-threshold pulses are applied in both directions: rising on rail 2 and falling on rail 1. A filter that keeps its count across the interruption, or filters the wrong edge, would release the reset or drop power-good when it should not. The power-good pin is also looped back into a manual input, so a reset that ignored input B would release while rail 1 is low.

// File: rtl/ssv_pkg.sv
package ssv_pkg;
  // Which edge a deglitch filter delays; the opposite edge passes at once.
  typedef enum logic {FILT_RISE = 1'b0, FILT_FALL = 1'b1} filt_edge_e;
endpackage

// File: rtl/ssv_sync.sv
module ssv_sync #(
  parameter int          W       = 1,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1_q, s2_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1_q <= RST_VAL[i];
        s2_q <= RST_VAL[i];
      end else begin
        s1_q <= d_i[i];
        s2_q <= s1_q;
      end
    end
    assign q_o[i] = s2_q;
  end
endmodule

// File: rtl/ssv_edge_filter.sv
module ssv_edge_filter
  import ssv_pkg::*;
#(
  parameter int         CYCLES = 4,
  parameter filt_edge_e EDGE   = FILT_RISE
) (
  input  logic clk,
  input  logic rst_n,
  input  logic in_i,
  output logic out_o
);
  localparam int       CW     = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);
  localparam logic     TARGET = (EDGE == FILT_RISE);

  logic [CW-1:0] cnt_q;
  logic          out_q;
  logic          at_target_lvl;

  assign at_target_lvl = (in_i == TARGET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b0;
    end else if (!at_target_lvl) begin
      cnt_q <= '0;
      out_q <= ~TARGET;
    end else if (out_q != TARGET) begin
      if (cnt_q == LAST) begin
        cnt_q <= '0;
        out_q <= TARGET;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign out_o = out_q;

  if (EDGE == FILT_RISE) begin : g_rise_chk
    // R3
    rise_drop_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_i |=> !out_o);
    // R6
    rise_needs_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_o) |-> $past(in_i));
  end else begin : g_fall_chk
    // R7
    fall_rise_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_i |=> out_o);
    // R8
    fall_needs_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(out_o) |-> !$past(in_i));
  end
endmodule

// File: rtl/ssv_holdoff.sv
module ssv_holdoff #(
  parameter int HOLD_CYCLES = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ok_i,
  output logic release_o
);
  localparam int            CW   = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(HOLD_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          rel_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else if (!ok_i) begin
      cnt_q <= '0;
      rel_q <= 1'b0;
    end else if (!rel_q) begin
      if (cnt_q == LAST) begin
        rel_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign release_o = rel_q;

  // R5
  drop_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ok_i |=> !release_o);
  // R5
  full_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(release_o) |-> ($past(cnt_q) == LAST) && $past(ok_i));
endmodule

// File: rtl/supply_supervisor.sv
module supply_supervisor
  import ssv_pkg::*;
#(
  parameter int HOLD_CYCLES    = 24_000_000,
  parameter int RISE_DG_CYCLES = 6000,
  parameter int PG_DG_CYCLES   = 6000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rail2_ok_i,
  input  logic rail1_ok_i,
  input  logic mr_a_n_i,
  input  logic mr_b_n_i,
  output logic rst_out_oe_o,
  output logic pg_out_oe_o
);
  // Synchronized bits: {rail1, mr_b, mr_a, rail2}; manual inputs idle high.
  logic [3:0] raw_in, syn_q;
  logic       rail2_s, mr_a_s, mr_b_s, rail1_s;
  logic       rail2_q, pg_q, all_ok, released;

  assign raw_in = {rail1_ok_i, mr_b_n_i, mr_a_n_i, rail2_ok_i};

  ssv_sync #(.W(4), .RST_VAL(4'b0110)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(raw_in), .q_o(syn_q)
  );

  assign rail2_s = syn_q[0];
  assign mr_a_s  = syn_q[1];
  assign mr_b_s  = syn_q[2];
  assign rail1_s = syn_q[3];

  ssv_edge_filter #(.CYCLES(RISE_DG_CYCLES), .EDGE(FILT_RISE)) u_rail2_dg (
    .clk(clk), .rst_n(rst_n), .in_i(rail2_s), .out_o(rail2_q)
  );

  ssv_edge_filter #(.CYCLES(PG_DG_CYCLES), .EDGE(FILT_FALL)) u_rail1_dg (
    .clk(clk), .rst_n(rst_n), .in_i(rail1_s), .out_o(pg_q)
  );

  assign all_ok = rail2_q & mr_a_s & mr_b_s;

  ssv_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
    .clk(clk), .rst_n(rst_n), .ok_i(all_ok), .release_o(released)
  );

  // Loss of any condition pulls the pin at once, not one cycle later.
  assign rst_out_oe_o = ~(released & all_ok);
  assign pg_out_oe_o  = ~pg_q;

  // R1
  rst_in_reset_chk: assert property (@(posedge clk) !rst_n |-> rst_out_oe_o && pg_out_oe_o);
  // R3
  rail2_low_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rail2_q |-> rst_out_oe_o);
  // R4
  manual_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mr_a_s || !mr_b_s) |-> rst_out_oe_o);
  // R7
  pg_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pg_out_oe_o) |-> $past(rail1_s));
endmodule

// File: tb/supply_supervisor_tb_top.sv
`timescale 1ns/1ps
module supply_supervisor_tb_top;
  localparam int H  = 40;
  localparam int RD = 6;
  localparam int PD = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rail2 = 1'b0, rail1 = 1'b0, mr_a = 1'b1, mr_b_drv = 1'b1, tie_pg = 1'b0;
  logic mr_b, rst_oe, pg_oe;
  int   total = 0, bad = 0;

  always #2.5 clk = ~clk;

  // Optional wiring of the power-good pin into manual input B.
  assign mr_b = tie_pg ? ~pg_oe : mr_b_drv;

  supply_supervisor #(.HOLD_CYCLES(H), .RISE_DG_CYCLES(RD), .PG_DG_CYCLES(PD)) dut_i (
    .clk(clk), .rst_n(rst_n), .rail2_ok_i(rail2), .rail1_ok_i(rail1),
    .mr_a_n_i(mr_a), .mr_b_n_i(mr_b), .rst_out_oe_o(rst_oe), .pg_out_oe_o(pg_oe)
  );

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset();
    tick(3);
    check("R1 rst during reset", rst_oe, 1'b1);
    check("R1 pg during reset", pg_oe, 1'b1);
    @(negedge clk) rst_n = 1'b1;
    tick(4);
    check("R1 rst after reset", rst_oe, 1'b1);
    check("R1 pg after reset", pg_oe, 1'b1);
  endtask

  task automatic t_release();
    @(negedge clk) rail2 = 1'b1;
    tick(RD + H + 1);
    check("R2 held one edge early", rst_oe, 1'b1);
    tick(1);
    check("R2 released on time", rst_oe, 1'b0);
  endtask

  task automatic t_manual(input bit use_b);
    @(negedge clk) if (use_b) mr_b_drv = 1'b0; else mr_a = 1'b0;
    tick(1);
    check("R4 not yet asserted", rst_oe, 1'b0);
    tick(1);
    check("R4 manual asserts", rst_oe, 1'b1);
    @(negedge clk) if (use_b) mr_b_drv = 1'b1; else mr_a = 1'b1;
    tick(H + 1);
    check("R5 full delay after manual", rst_oe, 1'b1);
    tick(1);
    check("R5 release after manual", rst_oe, 1'b0);
  endtask

  task automatic t_restart();
    @(negedge clk) mr_a = 1'b0;
    @(negedge clk) mr_a = 1'b1;
    tick(H - 5);
    check("R5 partial count holds", rst_oe, 1'b1);
    @(negedge clk) mr_a = 1'b0;
    @(negedge clk) mr_a = 1'b1;
    tick(H + 1);
    check("R5 restarted count holds", rst_oe, 1'b1);
    tick(1);
    check("R5 release after restart", rst_oe, 1'b0);
  endtask

  task automatic t_rail2_drop();
    @(negedge clk) rail2 = 1'b0;
    tick(2);
    check("R3 not yet asserted", rst_oe, 1'b0);
    tick(1);
    check("R3 rail2 drop asserts", rst_oe, 1'b1);
  endtask

  task automatic t_rail2_glitch();
    @(negedge clk) rail2 = 1'b1;
    repeat (RD - 1) @(negedge clk);
    rail2 = 1'b0;
    tick(RD + H + 10);
    check("R6 short high ignored", rst_oe, 1'b1);
    @(negedge clk) rail2 = 1'b1;
    tick(RD + H + 1);
    check("R2 held after glitch", rst_oe, 1'b1);
    tick(1);
    check("R2 released after glitch", rst_oe, 1'b0);
  endtask

  task automatic t_pg();
    @(negedge clk) rail1 = 1'b1;
    tick(2);
    check("R7 pg not yet good", pg_oe, 1'b1);
    tick(1);
    check("R7 pg good", pg_oe, 1'b0);
    @(negedge clk) rail1 = 1'b0;
    repeat (PD - 1) @(negedge clk);
    rail1 = 1'b1;
    tick(PD + 5);
    check("R8 short dip ignored", pg_oe, 1'b0);
    @(negedge clk) rail1 = 1'b0;
    tick(PD + 1);
    check("R8 pg still good", pg_oe, 1'b0);
    tick(1);
    check("R8 pg falls", pg_oe, 1'b1);
  endtask

  task automatic t_tie();
    @(negedge clk) tie_pg = 1'b1;
    tick(H + RD + 5);
    check("R9 rail1 low holds reset", rst_oe, 1'b1);
    @(negedge clk) rail1 = 1'b1;
    tick(H + 4);
    check("R9 held during delay", rst_oe, 1'b1);
    tick(1);
    check("R9 released via pg", rst_oe, 1'b0);
    @(negedge clk) rail1 = 1'b0;
    tick(PD + 3);
    check("R9 not yet asserted", rst_oe, 1'b0);
    tick(1);
    check("R9 rail1 loss asserts", rst_oe, 1'b1);
  endtask

  initial begin
    t_reset();
    t_release();
    t_manual(1'b0);
    t_manual(1'b1);
    t_restart();
    t_rail2_drop();
    t_rail2_glitch();
    t_pg();
    t_tie();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule